// File: doc/BRIEF.md
# Multi-Mode Operand Address Generator

This unit forms the effective memory address for a load-style operand from a 4-bit mode code and a set of operands: a base register value, an index register value, the program counter, a 16-bit displacement that is sign-extended inside the unit, and a 2-bit scale selector. Most modes finish in the cycle of the request. The result is a combinational address with a valid strobe. Three modes also return an updated base value with a writeback enable, so a loop can walk through an array without separate address arithmetic.

One mode, memory indirect, takes two accesses. The unit first reads memory at the base address through a simple request/acknowledge port. It then returns the fetched word as the operand address. While that sequence runs, the unit reports busy and ignores new requests. Register reads, the data load and instruction decoding belong to the surrounding pipeline.

Top module: `opaddr_gen`

## Requirements
- R1: After reset the unit is idle: `busy_o`, `addr_valid_o`, `wb_en_o`, `illegal_o` and `mem_req_o` are all 0.
- R2: Mode 0 (register indirect): an idle request gives `addr_o = base_i` with `addr_valid_o = 1` in the same cycle.
- R3: Mode 1 gives `base_i + sext(disp_i)`. Mode 2 gives `pc_i + sext(disp_i)`. The 16-bit displacement is sign-extended from bit 15. Both results are valid in the request cycle.
- R4: Mode 3 (base plus index) gives `base_i + index_i` in the request cycle.
- R5: Mode 4 (scaled index) gives `base_i + (index_i << scale_i)`, which scales the index by 1, 2, 4 or 8.
- R6: Mode 5 (post-increment) gives `addr_o = base_i` and `wb_data_o = base_i + (1 << scale_i)`. Mode 6 (post-decrement) gives the same address and `wb_data_o = base_i - (1 << scale_i)`. Both assert `wb_en_o`.
- R7: Mode 7 (pre-update) gives `addr_o = wb_data_o = base_i + sext(disp_i)` and asserts `wb_en_o`.
- R8: Mode 8 (memory indirect) runs as follows. In the cycle after the request, `mem_req_o` rises with `mem_addr_o = base_i`. Both hold until `mem_ack_i`. In the cycle after the acknowledge, `addr_valid_o` is high for exactly one cycle with `addr_o` equal to the `mem_rdata_i` that was captured. `busy_o` is high from the cycle after the request until the valid cycle ends. Requests made while busy produce no valid, writeback or illegal output.
- R9: Mode codes 9 to 15 raise `illegal_o` in the request cycle, with `addr_valid_o` and `wb_en_o` both 0.
- R10: `wb_en_o` is asserted only for modes 5, 6 and 7, and only in the same cycle as `addr_valid_o`.
- R11: All address sums and differences wrap modulo 2^32, and no overflow is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Address request |
| mode_i | input | 4 | Addressing mode code |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| pc_i | input | 32 | Program counter |
| disp_i | input | 16 | Displacement, sign-extended internally |
| scale_i | input | 2 | Shift amount for index scaling and step size |
| busy_o | output | 1 | Memory-indirect sequence in progress |
| addr_valid_o | output | 1 | Address result valid |
| addr_o | output | 32 | Effective address |
| illegal_o | output | 1 | Unassigned mode requested |
| wb_en_o | output | 1 | Base writeback enable |
| wb_data_o | output | 32 | Updated base value |
| mem_req_o | output | 1 | Indirect-pointer read request |
| mem_addr_o | output | 32 | Indirect-pointer read address |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_rdata_i | input | 32 | Read data |

## Verification
Only the memory-indirect path has internal state, which is a three-state sequencer and two captured words. A wrong state shows at the ports within one cycle. It appears as a missing or doubled valid pulse, a read request that drops before its acknowledge, a changed read address during the wait, or a stuck busy that blocks the next request. A wrong captured pointer shows as a wrong address on the single valid cycle after the acknowledge. The combinational modes are checked against bench-computed sums over random operands, including carries that wrap past bit 31 and negative displacements.

// File: rtl/opaddr_gen.sv
module opaddr_gen #(
  parameter int AW = 32,
  parameter int DISP_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [3:0]    mode_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] index_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [1:0]    scale_i,
  output logic          busy_o,
  output logic          addr_valid_o,
  output logic [AW-1:0] addr_o,
  output logic          illegal_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_data_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ack_i,
  input  logic [AW-1:0] mem_rdata_i
);
  localparam logic [3:0] M_REGIND  = 4'd0;
  localparam logic [3:0] M_BDISP   = 4'd1;
  localparam logic [3:0] M_PCREL   = 4'd2;
  localparam logic [3:0] M_BIDX    = 4'd3;
  localparam logic [3:0] M_SCALED  = 4'd4;
  localparam logic [3:0] M_POSTINC = 4'd5;
  localparam logic [3:0] M_POSTDEC = 4'd6;
  localparam logic [3:0] M_PREUPD  = 4'd7;
  localparam logic [3:0] M_MEMIND  = 4'd8;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DONE} st_t;
  st_t state;
  logic [AW-1:0] ptr_q, ind_q;
  logic [AW-1:0] addr_c, wb_c;
  logic legal_c, wb_c_en, ind_c;

  wire go = req_i && (state == S_IDLE);
  wire [AW-1:0] disp_x = {{(AW-DISP_W){disp_i[DISP_W-1]}}, disp_i};
  wire [AW-1:0] step   = AW'(1) << scale_i;
  wire [AW-1:0] scaled = index_i << scale_i;

  always_comb begin
    addr_c  = base_i;
    wb_c    = base_i;
    legal_c = 1'b1;
    wb_c_en = 1'b0;
    ind_c   = 1'b0;
    case (mode_i)
      M_REGIND:  addr_c = base_i;
      M_BDISP:   addr_c = base_i + disp_x;
      M_PCREL:   addr_c = pc_i + disp_x;
      M_BIDX:    addr_c = base_i + index_i;
      M_SCALED:  addr_c = base_i + scaled;
      M_POSTINC: begin wb_c = base_i + step; wb_c_en = 1'b1; end
      M_POSTDEC: begin wb_c = base_i - step; wb_c_en = 1'b1; end
      M_PREUPD:  begin addr_c = base_i + disp_x; wb_c = addr_c; wb_c_en = 1'b1; end
      M_MEMIND:  ind_c = 1'b1;
      default:   legal_c = 1'b0;
    endcase
  end

  assign addr_valid_o = (go && legal_c && !ind_c) || (state == S_DONE);
  assign addr_o       = (state == S_DONE) ? ind_q : addr_c;
  assign wb_en_o      = go && wb_c_en;
  assign wb_data_o    = wb_c;
  assign illegal_o    = go && !legal_c;
  assign busy_o       = (state != S_IDLE);
  assign mem_req_o    = (state == S_WAIT);
  assign mem_addr_o   = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ptr_q <= '0;
      ind_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (go && ind_c) begin
          state <= S_WAIT;
          ptr_q <= base_i;
        end
        S_WAIT: if (mem_ack_i) begin
          state <= S_DONE;
          ind_q <= mem_rdata_i;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/opaddr_gen_chk.sv
module opaddr_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_i,
  input logic [3:0]    mode_i,
  input logic [AW-1:0] base_i,
  input logic [1:0]    scale_i,
  input logic          busy_o,
  input logic          addr_valid_o,
  input logic [AW-1:0] addr_o,
  input logic          illegal_o,
  input logic          wb_en_o,
  input logic [AW-1:0] wb_data_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_ack_i,
  input logic [AW-1:0] mem_rdata_i
);
  AST_WB_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> addr_valid_o && (mode_i >= 4'd5) && (mode_i <= 4'd7)); // R10

  AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !addr_valid_o && !wb_en_o && (mode_i >= 4'd9)); // R9

  AST_MEMREQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)); // R8

  AST_IND_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_ack_i |=> addr_valid_o && !mem_req_o && (addr_o == $past(mem_rdata_i))); // R8

  AST_POSTINC_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && !busy_o && mode_i == 4'd5 |-> addr_valid_o && wb_en_o && addr_o == base_i
      && wb_data_o == base_i + (AW'(1) << scale_i)); // R6

  AST_REGIND_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && !busy_o && mode_i == 4'd0 |-> addr_valid_o && addr_o == base_i); // R2
endmodule

bind opaddr_gen opaddr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i), .base_i(base_i),
  .scale_i(scale_i), .busy_o(busy_o), .addr_valid_o(addr_valid_o), .addr_o(addr_o),
  .illegal_o(illegal_o), .wb_en_o(wb_en_o), .wb_data_o(wb_data_o),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
  .mem_rdata_i(mem_rdata_i)
);

// File: tb/opaddr_gen_tb.sv
`timescale 1ns/1ps
module opaddr_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_i = 1'b0;
  logic [3:0] mode_i = '0;
  logic [31:0] base_i = '0, index_i = '0, pc_i = '0;
  logic [15:0] disp_i = '0;
  logic [1:0] scale_i = '0;
  logic busy_o, addr_valid_o, illegal_o, wb_en_o, mem_req_o;
  logic [31:0] addr_o, wb_data_o, mem_addr_o;
  logic mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  opaddr_gen u_dut (.*);

  function automatic logic [31:0] sx(input logic [15:0] d);
    return {{16{d[15]}}, d};
  endfunction

  function automatic logic [31:0] exp_addr(input logic [3:0] m);
    case (m)
      4'd1, 4'd7: return base_i + sx(disp_i);
      4'd2: return pc_i + sx(disp_i);
      4'd3: return base_i + index_i;
      4'd4: return base_i + (index_i << scale_i);
      default: return base_i;
    endcase
  endfunction

  function automatic logic [31:0] exp_wb(input logic [3:0] m);
    case (m)
      4'd5: return base_i + (32'd1 << scale_i);
      4'd6: return base_i - (32'd1 << scale_i);
      default: return base_i + sx(disp_i);
    endcase
  endfunction

  function automatic string tag(input logic [3:0] m);
    case (m)
      4'd0: return "R2";
      4'd1, 4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5, 4'd6: return "R6";
      4'd7: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic one_shot(input logic [3:0] m);
    logic legal, wbm;
    @(negedge clk);
    req_i = 1'b1; mode_i = m;
    #1;
    legal = (m <= 4'd7);
    wbm = (m >= 4'd5 && m <= 4'd7);
    chk({tag(m), " valid"}, 32'(addr_valid_o), 32'(legal));
    chk({tag(m), " illegal"}, 32'(illegal_o), 32'(!legal));
    chk({"R10 wb_en ", tag(m)}, 32'(wb_en_o), 32'(wbm));
    if (legal) chk({tag(m), " addr"}, addr_o, exp_addr(m));
    if (wbm) chk({tag(m), " wb_data"}, wb_data_o, exp_wb(m));
  endtask

  task automatic indirect(input logic [31:0] b, input logic [31:0] ptr, input int waits);
    @(negedge clk);
    req_i = 1'b1; mode_i = 4'd8; base_i = b;
    #1 chk("R8 no valid at request", 32'(addr_valid_o), 32'd0);
    @(negedge clk);
    req_i = 1'b1; mode_i = 4'd0; base_i = ~b;
    #1;
    chk("R8 mem_req", 32'(mem_req_o), 32'd1);
    chk("R8 mem_addr", mem_addr_o, b);
    chk("R8 busy", 32'(busy_o), 32'd1);
    chk("R8 ignored req valid", 32'(addr_valid_o | wb_en_o | illegal_o), 32'd0);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      mode_i = 4'(9 + (i % 7));
      #1;
      chk("R8 req held", 32'(mem_req_o), 32'd1);
      chk("R8 addr held", mem_addr_o, b);
      chk("R8 ignored while waiting", 32'(addr_valid_o | illegal_o), 32'd0);
    end
    @(negedge clk);
    req_i = 1'b0; mem_ack_i = 1'b1; mem_rdata_i = ptr;
    @(negedge clk);
    mem_ack_i = 1'b0; mem_rdata_i = ~ptr;
    #1;
    chk("R8 valid after ack", 32'(addr_valid_o), 32'd1);
    chk("R8 pointer address", addr_o, ptr);
    chk("R8 no request after ack", 32'(mem_req_o), 32'd0);
    chk("R8 no writeback", 32'(wb_en_o), 32'd0);
    @(negedge clk);
    #1;
    chk("R8 single valid", 32'(addr_valid_o), 32'd0);
    chk("R8 busy cleared", 32'(busy_o), 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    process::self().srandom(32'd20240611);
    repeat (3) @(negedge clk);
    #1;
    chk("R1 busy", 32'(busy_o), 32'd0);
    chk("R1 valid", 32'(addr_valid_o), 32'd0);
    chk("R1 mem_req", 32'(mem_req_o), 32'd0);
    chk("R1 wb/illegal", 32'(wb_en_o | illegal_o), 32'd0);
    rst_n = 1'b1;

    base_i = 32'hFFFF_FFF0; disp_i = 16'h0020; pc_i = 32'h0000_1000; index_i = 32'h20;
    one_shot(4'd1);
    chk("R11 wrap base+disp", addr_o, 32'h0000_0010);
    disp_i = 16'h8000;
    one_shot(4'd2);
    chk("R3 negative disp pc", addr_o, 32'hFFFF_9000);
    base_i = 32'h0000_0002; scale_i = 2'd3;
    one_shot(4'd6);
    chk("R11 wrap post-dec", wb_data_o, 32'hFFFF_FFFA);
    base_i = 32'h100; index_i = 32'h4000_0001; scale_i = 2'd3;
    one_shot(4'd4);
    chk("R5 scale 8", addr_o, 32'h0000_0108);
    disp_i = 16'hFFFC;
    one_shot(4'd7);
    chk("R7 pre-update same", wb_data_o, addr_o);
    for (int m = 9; m < 16; m++) one_shot(4'(m));
    @(negedge clk); req_i = 1'b0; #1;
    chk("R10 idle no wb", 32'(wb_en_o | addr_valid_o), 32'd0);

    indirect(32'h0000_8000, 32'hDEAD_BEE0, 0);
    indirect(32'h1234_5678, 32'h0BAD_F00D, 3);

    for (int n = 0; n < 400; n++) begin
      logic [3:0] m;
      base_i = $urandom; index_i = $urandom; pc_i = $urandom;
      disp_i = 16'($urandom); scale_i = 2'($urandom);
      m = 4'($urandom);
      if (m == 4'd8) indirect(base_i, $urandom, int'($urandom % 4));
      else one_shot(m);
      if (n % 5 == 0) begin
        @(negedge clk); req_i = 1'b0;
      end
    end
    @(negedge clk); req_i = 1'b0;
    done = 1;
    finish_run();
  end
endmodule